// File: doc/BRIEF.md
# Ping-Pong Lifting Sample Memory Controller

This block steers a sample store made of two main banks. Each bank has two halves. In every lifting step one half is read and the other half is written. The block produces the read stream that feeds a processing chain and the write stream that stores the chain's results. It also gates a host port, so that software can refill or drain the bank that is not in use while the other bank is being transformed. The arithmetic of the lifting steps lives elsewhere. This block only sequences addresses and enables.

A step is launched with a one-cycle `start`. At that moment the block captures five settings:
- the bank,
- a length code (the active region is the half size shifted right by the code),
- a pair offset that makes the reads wrap periodically inside the page,
- the output layout: interleaved low/high, or split into a low page and a high page,
- the pipeline latency of the chain.

The controller has four states:
- `ST_IDLE` waits for `start`.
- `ST_FILL` runs the source and counts the latency. It is skipped when the latency is zero.
- `ST_STREAM` runs the sink, and the source until the source is exhausted.
- `ST_SWAP` lasts one cycle. It raises `done` and exchanges the read and write halves of the bank just used.

The transitions are:
- IDLE→FILL on `start` with a non-zero latency.
- IDLE→STREAM on `start` with a zero latency.
- FILL→STREAM when the latency count expires.
- STREAM→SWAP on the last sink write.
- SWAP→IDLE always.

Top module: `pp_lift_mem`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `rd_en` and `wr_en` are low, and in both banks half 0 is the read half and half 1 is the write half.
- R2: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` seen while `busy` is ignored, and every setting is latched only when a `start` is accepted.
- R3: The source issues N reads on consecutive cycles, beginning the first cycle after `start`. Read k uses pair index ((offset + k/2) mod N/2). Its word address is 2·pair + (k mod 2), so the even word comes first.
- R4: For a length code L, N = 2^(AW−L). Codes of AW−1 or more give N = 2, which is one pair.
- R5: The first sink write happens exactly `lat` cycles after the first read. The N writes then follow on consecutive cycles.
- R6: With `split_mode` = 0, sink write k goes to word 2·(k/2) + (k mod 2), giving the order L,H,L,H.
- R7: With `split_mode` = 1, sink write k goes to word k/2 when k is even (low page). When k is odd it goes to word N/2 + k/2 (high page).
- R8: An address is {bank (MSB), half, word (AW bits)}. Reads use the read half of the latched bank, and writes use the other half of that bank.
- R9: `done` is a one-cycle pulse in the cycle after the last write. From the next cycle on, the read and write halves of that bank are exchanged. The other bank is left unchanged.
- R10: A host request to the latched bank while `busy` raises `host_err` and no `host_ok`. Every other request raises `host_ok`. A host write is addressed to the bank's current write half and a host read to its current read half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one lifting step |
| bank_sel | input | 1 | Bank to process |
| len_code | input | LENW | Length code, power-of-two fraction of a half |
| rd_off | input | AW-1 | Starting pair offset for periodic reads |
| split_mode | input | 1 | 0 = interleaved results, 1 = low/high pages |
| lat | input | LATW | Cycles from first read to first write |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_bank | input | 1 | Bank the host targets |
| host_word | input | AW | Word within the half |
| rd_en | output | 1 | Source read enable |
| rd_addr | output | AW+2 | Source read address |
| wr_en | output | 1 | Sink write enable |
| wr_addr | output | AW+2 | Sink write address |
| busy | output | 1 | Step in progress |
| done | output | 1 | Step finished, roles swapped |
| host_ok | output | 1 | Host access granted |
| host_err | output | 1 | Host access refused, bank busy |
| host_addr | output | AW+2 | Physical address of the host access |

## Verification
The bench aims at the following corner cases:
- **Pair wrap.** Offsets near the top of a page check the wrap in the pair index. A design that wrapped at the full half instead of the active page would read outside the region.
- **Latency extremes.** Latencies of zero and of more than the whole read burst check the FILL bypass and the long wait. A mistake here shows up as writes one cycle early or late, or writes that overlap the reads incorrectly.
- **Length clamping.** Length codes above the smallest page check the clamp. Without it the block would stream zero or a negative number of samples.
- **Repeated steps on one bank.** These check that the halves alternate, so that a missing swap would overwrite the data just read.
- **Stray start and host collisions.** Starts during a step, and host requests to the busy bank, check that settings are never re-latched and that the active bank is never granted to the host.

// File: rtl/pp_lift_pkg.sv
package pp_lift_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2,
        ST_SWAP   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pp_seq_ctrl.sv
module pp_seq_ctrl
    import pp_lift_pkg::*;
#(
    parameter int LATW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LATW-1:0] lat_in,
    input  logic            snk_last,
    output logic            cfg_load,
    output logic            src_run,
    output logic            snk_run,
    output logic            busy,
    output logic            done
);
    seq_state_t state_q, state_d;
    logic [LATW-1:0] lat_q;
    logic [LATW-1:0] lat_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (lat_in == '0) ? ST_STREAM : ST_FILL;
            ST_FILL:   if (lat_cnt == lat_q - 1'b1) state_d = ST_STREAM;
            ST_STREAM: if (snk_last) state_d = ST_SWAP;
            ST_SWAP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // latency counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q   <= '0;
            lat_cnt <= '0;
        end else if (cfg_load) begin
            lat_q   <= lat_in;
            lat_cnt <= '0;
        end else if (state_q == ST_FILL) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cfg_load = 1'b0;
        src_run  = 1'b0;
        snk_run  = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                cfg_load = start;
            end
            ST_FILL:   src_run = 1'b1;
            ST_STREAM: begin
                src_run = 1'b1;
                snk_run = 1'b1;
            end
            ST_SWAP:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pp_src_agen.sv
module pp_src_agen #(
    parameter int AW  = 5,
    parameter int SHW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [SHW-1:0] lsh,
    input  logic [AW-2:0] off,
    output logic          en,
    output logic [AW-1:0] word
);
    localparam logic [AW:0]   FULL = (AW+1)'(1) << AW;
    localparam logic [AW-2:0] ONES = '1;

    logic [AW:0]   cnt;
    logic [AW:0]   n_len;
    logic [AW-2:0] pmask;
    logic [AW-2:0] pair;

    assign n_len = FULL >> lsh;
    assign pmask = ONES >> lsh;
    assign en    = run && (cnt < n_len);
    assign pair  = (off + cnt[AW-1:1]) & pmask;
    assign word  = {pair, cnt[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (en)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pp_snk_agen.sv
module pp_snk_agen #(
    parameter int AW  = 5,
    parameter int SHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           run,
    input  logic [SHW-1:0] lsh,
    input  logic           split,
    output logic           en,
    output logic           last,
    output logic [AW-1:0]  word
);
    localparam logic [AW:0]   FULL = (AW+1)'(1) << AW;
    localparam logic [AW-1:0] HALF = AW'(1) << (AW-1);

    logic [AW:0]   cnt;
    logic [AW:0]   n_len;
    logic [AW-1:0] page_bit;
    logic [AW-1:0] j_word;
    logic [AW-1:0] il_word;
    logic [AW-1:0] sp_word;

    assign n_len    = FULL >> lsh;
    assign page_bit = HALF >> lsh;
    assign en       = run && (cnt < n_len);
    assign last     = en && (cnt == n_len - 1'b1);
    assign j_word   = {1'b0, cnt[AW-1:1]};
    assign il_word  = {cnt[AW-1:1], cnt[0]};
    assign sp_word  = cnt[0] ? (j_word | page_bit) : j_word;
    assign word     = split ? sp_word : il_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (en)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pp_host_gate.sv
module pp_host_gate #(
    parameter int AW = 5
) (
    input  logic          busy,
    input  logic          act_bank,
    input  logic [1:0]    rd_half,
    input  logic          host_req,
    input  logic          host_we,
    input  logic          host_bank,
    input  logic [AW-1:0] host_word,
    output logic          host_ok,
    output logic          host_err,
    output logic [AW+1:0] host_addr
);
    logic half;

    assign host_err  = host_req && busy && (host_bank == act_bank);
    assign host_ok   = host_req && !host_err;
    assign half      = host_we ? ~rd_half[host_bank] : rd_half[host_bank];
    assign host_addr = {host_bank, half, host_word};
endmodule

// File: rtl/pp_lift_mem.sv
module pp_lift_mem #(
    parameter int AW   = 5,
    parameter int LENW = 3,
    parameter int LATW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            bank_sel,
    input  logic [LENW-1:0] len_code,
    input  logic [AW-2:0]   rd_off,
    input  logic            split_mode,
    input  logic [LATW-1:0] lat,
    input  logic            host_req,
    input  logic            host_we,
    input  logic            host_bank,
    input  logic [AW-1:0]   host_word,
    output logic            rd_en,
    output logic [AW+1:0]   rd_addr,
    output logic            wr_en,
    output logic [AW+1:0]   wr_addr,
    output logic            busy,
    output logic            done,
    output logic            host_ok,
    output logic            host_err,
    output logic [AW+1:0]   host_addr
);
    localparam int SHW = $clog2(AW);

    logic           cfg_load, src_run, snk_run, snk_last;
    logic           bank_q, split_q;
    logic [SHW-1:0] lsh_q, lsh_in;
    logic [AW-2:0]  off_q;
    logic [1:0]     rd_half;
    logic [AW-1:0]  src_word, snk_word;

    assign lsh_in = (int'(len_code) >= AW - 1) ? SHW'(AW - 1) : SHW'(len_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= 1'b0;
            split_q <= 1'b0;
            lsh_q   <= '0;
            off_q   <= '0;
        end else if (cfg_load) begin
            bank_q  <= bank_sel;
            split_q <= split_mode;
            lsh_q   <= lsh_in;
            off_q   <= rd_off;
        end
    end

    // role of each bank's halves; toggles when its step completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rd_half <= 2'b00;
        else if (done) rd_half[bank_q] <= ~rd_half[bank_q];
    end

    pp_seq_ctrl #(.LATW(LATW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lat_in(lat),
        .snk_last(snk_last), .cfg_load(cfg_load), .src_run(src_run),
        .snk_run(snk_run), .busy(busy), .done(done)
    );

    pp_src_agen #(.AW(AW), .SHW(SHW)) u_src (
        .clk(clk), .rst_n(rst_n), .clear(cfg_load), .run(src_run),
        .lsh(lsh_q), .off(off_q), .en(rd_en), .word(src_word)
    );

    pp_snk_agen #(.AW(AW), .SHW(SHW)) u_snk (
        .clk(clk), .rst_n(rst_n), .clear(cfg_load), .run(snk_run),
        .lsh(lsh_q), .split(split_q), .en(wr_en), .last(snk_last),
        .word(snk_word)
    );

    pp_host_gate #(.AW(AW)) u_host (
        .busy(busy), .act_bank(bank_q), .rd_half(rd_half),
        .host_req(host_req), .host_we(host_we), .host_bank(host_bank),
        .host_word(host_word), .host_ok(host_ok), .host_err(host_err),
        .host_addr(host_addr)
    );

    assign rd_addr = {bank_q, rd_half[bank_q], src_word};
    assign wr_addr = {bank_q, ~rd_half[bank_q], snk_word};
endmodule

// File: rtl/pp_lift_mem_chk.sv
module pp_lift_mem_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          rd_en,
    input logic [AW+1:0] rd_addr,
    input logic          wr_en,
    input logic [AW+1:0] wr_addr,
    input logic          busy,
    input logic          done,
    input logic          host_ok,
    input logic [AW+1:0] host_addr
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en));

    assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_src_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rd_en && !rd_addr[0]));

    assert_half_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> ((rd_addr[AW+1] == wr_addr[AW+1]) && (rd_addr[AW] != wr_addr[AW])));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && !wr_en && busy));

    assert_host_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ok && rd_en) |-> (host_addr[AW+1] != rd_addr[AW+1]));
endmodule

bind pp_lift_mem pp_lift_mem_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy), .done(done),
    .host_ok(host_ok), .host_addr(host_addr)
);

// File: tb/pp_lift_mem_test.sv
module pp_lift_mem_test;
    localparam int AW   = 5;
    localparam int LENW = 3;
    localparam int LATW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, bank_sel = 1'b0, split_mode = 1'b0;
    logic [LENW-1:0] len_code = '0;
    logic [AW-2:0] rd_off = '0;
    logic [LATW-1:0] lat = '0;
    logic host_req = 1'b0, host_we = 1'b0, host_bank = 1'b0;
    logic [AW-1:0] host_word = '0;
    logic rd_en, wr_en, busy, done, host_ok, host_err;
    logic [AW+1:0] rd_addr, wr_addr, host_addr;

    int checks = 0, failures = 0;
    int mhalf [2];

    always #5 clk = ~clk;

    pp_lift_mem #(.AW(AW), .LENW(LENW), .LATW(LATW)) uut (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_shift(int code);
        return (code >= AW - 1) ? AW - 1 : code;
    endfunction

    function automatic int src_word(int k, int off, int n);
        return (((off + k / 2) % (n / 2)) * 2) + (k % 2);
    endfunction

    function automatic int snk_word(int k, int n, bit split);
        if (!split) return k;
        return (k % 2) ? (n / 2 + k / 2) : (k / 2);
    endfunction

    function automatic int paddr(int b, int h, int w);
        return (b << (AW + 1)) | (h << AW) | w;
    endfunction

    task automatic check_host(bit busy_exp, int act_bank);
        bit err_exp;
        int half;
        err_exp = host_req && busy_exp && (int'(host_bank) == act_bank);
        half = host_we ? 1 - mhalf[host_bank] : mhalf[host_bank];
        check("R10 host_err", int'(host_err), int'(err_exp));
        check("R10 host_ok", int'(host_ok), int'(host_req && !err_exp));
        check("R10 host_addr", int'(host_addr), paddr(host_bank, half, host_word));
    endtask

    task automatic rand_host();
        host_req  = 1'($urandom);
        host_we   = 1'($urandom);
        host_bank = 1'($urandom);
        host_word = AW'($urandom);
    endtask

    task automatic run_step(int b, int code, int off, bit split, int lt, bit stray);
        int n, h;
        n = 1 << (AW - eff_shift(code));
        h = mhalf[b];
        @(negedge clk);
        start = 1'b1; bank_sel = 1'(b); len_code = LENW'(code);
        rd_off = (AW-1)'(off); split_mode = split; lat = LATW'(lt);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= lt + n + 1; k++) begin
            bit se, we;
            se = (k < n);
            we = (k >= lt) && (k < lt + n);
            check("R2 busy", int'(busy), int'(k <= lt + n));
            check("R3 rd_en", int'(rd_en), int'(se));
            if (se && rd_en)
                check("R3 R4 R8 rd_addr", int'(rd_addr), paddr(b, h, src_word(k, off % (1 << (AW-1)), n)));
            check("R5 wr_en", int'(wr_en), int'(we));
            if (we && wr_en) begin
                if (split) check("R7 R8 wr_addr split", int'(wr_addr), paddr(b, 1 - h, snk_word(k - lt, n, 1'b1)));
                else       check("R6 R8 wr_addr interleaved", int'(wr_addr), paddr(b, 1 - h, snk_word(k - lt, n, 1'b0)));
            end
            check("R9 done", int'(done), int'(k == lt + n));
            if (k == lt + n + 1) mhalf[b] = 1 - mhalf[b];
            check_host(k <= lt + n, b);
            rand_host();
            if (stray && k == 1) begin
                start = 1'b1; bank_sel = ~1'(b); split_mode = ~split;
                len_code = LENW'($urandom); rd_off = (AW-1)'($urandom); lat = LATW'($urandom);
            end
            if (k == 2) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        mhalf[0] = 0; mhalf[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 rd_en", int'(rd_en), 0);
        check("R1 wr_en", int'(wr_en), 0);
        host_req = 1'b1; host_bank = 1'b0; host_we = 1'b0; host_word = 5'd3;
        @(negedge clk);
        check("R1 read half 0", int'(host_addr), paddr(0, 0, 3));
        host_we = 1'b1; host_bank = 1'b1;
        @(negedge clk);
        check("R1 write half 1", int'(host_addr), paddr(1, 1, 3));
        check_host(1'b0, 0);

        // directed corners
        run_step(0, 0, 15, 1'b0, 0, 1'b0);   // R3 wrap, R5 zero latency
        run_step(0, 0, 3, 1'b1, 1, 1'b0);    // R7, R9 second step same bank
        run_step(1, 7, 0, 1'b1, 63, 1'b0);   // R4 clamp, R5 long latency
        run_step(1, 4, 1, 1'b0, 2, 1'b1);    // R4 boundary, R2 stray start
        run_step(0, 2, 7, 1'b1, 5, 1'b1);    // R2 stray start, R7
        run_step(1, 1, 6, 1'b0, 40, 1'b0);   // R5 latency beyond burst

        // constrained random
        for (int i = 0; i < 150; i++) begin
            run_step(int'($urandom_range(1, 0)), int'($urandom_range(7, 0)),
                     int'($urandom_range(15, 0)), 1'($urandom),
                     int'($urandom_range(20, 0)), 1'($urandom_range(3, 0) == 0));
            repeat (int'($urandom_range(2, 0))) begin
                check("R1 idle between steps", int'(busy), 0);
                check_host(1'b0, 0);
                rand_host();
                @(negedge clk);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule